// File: doc/BRIEF.md
# Landing Pad Retirement Checker

This block enforces forward-edge control-flow integrity at the commit stage of an in-order core. Once an indirect jump or call retires, the next instruction that retires without speculation must be a landing pad. The landing pad's embedded label must equal a label that software placed in architectural register x7 before the jump. If that rule is broken, the block raises a control-flow exception on the commit port concerned and blocks retirement on that port and on every port above it.

The core may retire several instructions per cycle. The block holds one combinational slice per commit port, and the slices are chained from port 0 upwards. The waiting flag, the tracked label and the kill condition all pass up the chain within the cycle. A jump and its landing pad can therefore retire together on adjacent ports. Checking is switched on separately for each privilege level. A trap entry or a pipeline flush returns the block to its idle state.

Top module: `lp_retire_guard`

## Requirements
- R1: After reset the block is idle and the tracked label is zero. A non-pad instruction retires with no exception, and a jump followed by a pad with label 0 is accepted.
- R2: A landing pad is an instruction with opcode bits [6:0] = 7'b0010111 (AUIPC) and destination bits [11:7] = 0. Its label is bits [31:12]. An AUIPC with any other destination is an ordinary instruction.
- R3: A retiring indirect jump is allowed, raises no exception and puts the block in the waiting state.
- R4: A pad that retires while the block is waiting is allowed and returns the block to idle when its zero-extended 20-bit label equals the full 32-bit tracked label. Otherwise it raises an exception.
- R5: A pad that retires while the block is idle is allowed and leaves the block idle.
- R6: Any instruction other than a pad that retires while the block is waiting raises an exception. This includes another indirect jump.
- R7: An allowed retirement that writes register index 7 loads its write data into the tracked label. The new value is visible to higher ports in the same cycle and to all later cycles.
- R8: A port that is invalid or has its speculative bit set gets neither allow nor exception, and it changes neither the state nor the label.
- R9: The waiting state set by a jump on a lower port is checked by a higher port in the same cycle. A pad on a higher port then clears it.
- R10: An exception on a port suppresses allow and exception on every higher port in that cycle. The excepting instruction's label write and state change are discarded.
- R11: Checking applies only when the enable bit indexed by the current privilege is set. With that bit clear, every valid non-speculative instruction is allowed, no exception is raised, and the waiting state is unchanged, but writes to x7 are still tracked.
- R12: A trap-entry or flush pulse forces the block to idle for the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | NUM_PORTS | Commit port holds a retiring instruction |
| spec_i | input | NUM_PORTS | Instruction is still speculative |
| instr_i | input | NUM_PORTS x 32 | Raw instruction word per port |
| ijmp_i | input | NUM_PORTS | Instruction is an indirect jump or call |
| wen_i | input | NUM_PORTS | Instruction writes a register |
| waddr_i | input | NUM_PORTS x 5 | Destination register index |
| wdata_i | input | NUM_PORTS x 32 | Register write data |
| chk_en_i | input | NUM_PRIV | Checking enable, one bit per privilege level |
| priv_i | input | PRIV_W | Current privilege level |
| trap_i | input | 1 | Trap entry, clears waiting state |
| flush_i | input | 1 | Pipeline flush, clears waiting state |
| allow_o | output | NUM_PORTS | Retirement permitted on this port |
| cfi_exc_o | output | NUM_PORTS | Control-flow exception on this port |

## Verification
The jump-then-pad sequence is run in three forms. In the first, the label matches. In the second, the 20-bit label differs. In the third, only the upper label bits differ. Together they separate a full-width compare from a truncated one. AUIPC words that are not pads, and plain instructions or a second jump after a jump, show that only true pads satisfy the obligation. Two-port patterns place the jump and pad in the same cycle, or place an excepting instruction below a healthy one, to show that the wait flag and kill condition pass up the chain. Speculative slots, disabled privilege levels and trap or flush pulses show which inputs must leave the state and label untouched.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
    localparam int XLEN       = 32;
    localparam int REG_IDX_W  = 5;
    localparam int PAD_LBL_W  = 20;
    localparam int LABEL_REG  = 7;
    localparam logic [6:0] OPC_AUIPC = 7'b0010111;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } lp_state_e;

    typedef struct packed {
        lp_state_e       st;
        logic [XLEN-1:0] label;
    } guard_state_t;
endpackage

// File: rtl/lpg_pad_decode.sv
module lpg_pad_decode
    import lpg_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output logic            is_pad_o,
    output logic [XLEN-1:0] pad_label_o
);
    localparam int LBL_LSB = XLEN - PAD_LBL_W;

    always_comb begin
        is_pad_o    = (instr_i[6:0] == OPC_AUIPC) && (instr_i[11:7] == '0);
        pad_label_o = {{(XLEN-PAD_LBL_W){1'b0}}, instr_i[XLEN-1:LBL_LSB]};
    end
endmodule

// File: rtl/lpg_slice.sv
module lpg_slice
    import lpg_pkg::*;
(
    input  logic                 en_i,
    input  logic                 valid_i,
    input  logic                 spec_i,
    input  logic [XLEN-1:0]      instr_i,
    input  logic                 ijmp_i,
    input  logic                 wen_i,
    input  logic [REG_IDX_W-1:0] waddr_i,
    input  logic [XLEN-1:0]      wdata_i,
    input  logic                 wait_i,
    input  logic [XLEN-1:0]      label_i,
    input  logic                 kill_i,
    output logic                 wait_o,
    output logic [XLEN-1:0]      label_o,
    output logic                 kill_o,
    output logic                 allow_o,
    output logic                 exc_o
);
    logic            is_pad;
    logic [XLEN-1:0] pad_label;
    logic            active;

    lpg_pad_decode u_dec (
        .instr_i    (instr_i),
        .is_pad_o   (is_pad),
        .pad_label_o(pad_label)
    );

    assign active = valid_i && !spec_i && !kill_i;

    always_comb begin
        exc_o   = 1'b0;
        wait_o  = wait_i;
        label_o = label_i;
        if (active) begin
            if (en_i) begin
                if (wait_i && !(is_pad && (pad_label == label_i))) begin
                    exc_o = 1'b1;
                end else if (ijmp_i) begin
                    wait_o = 1'b1;
                end else if (is_pad) begin
                    wait_o = 1'b0;
                end
            end
            if (!exc_o && wen_i && (waddr_i == REG_IDX_W'(LABEL_REG))) begin
                label_o = wdata_i;
            end
        end
    end

    assign allow_o = active && !exc_o;
    assign kill_o  = kill_i || exc_o;
endmodule

// File: rtl/lp_retire_guard.sv
module lp_retire_guard
    import lpg_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_PRIV  = 4,
    localparam int PRIV_W   = (NUM_PRIV > 1) ? $clog2(NUM_PRIV) : 1
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [NUM_PORTS-1:0]                valid_i,
    input  logic [NUM_PORTS-1:0]                spec_i,
    input  logic [NUM_PORTS-1:0][XLEN-1:0]      instr_i,
    input  logic [NUM_PORTS-1:0]                ijmp_i,
    input  logic [NUM_PORTS-1:0]                wen_i,
    input  logic [NUM_PORTS-1:0][REG_IDX_W-1:0] waddr_i,
    input  logic [NUM_PORTS-1:0][XLEN-1:0]      wdata_i,
    input  logic [NUM_PRIV-1:0]                 chk_en_i,
    input  logic [PRIV_W-1:0]                   priv_i,
    input  logic                                trap_i,
    input  logic                                flush_i,
    output logic [NUM_PORTS-1:0]                allow_o,
    output logic [NUM_PORTS-1:0]                cfi_exc_o
);
    guard_state_t state_d, state_q;

    logic [NUM_PORTS:0]           wait_c;
    logic [NUM_PORTS:0]           kill_c;
    logic [NUM_PORTS:0][XLEN-1:0] label_c;
    logic                         chk_en;
    logic                         waiting_q;
    logic [XLEN-1:0]              label_q;

    assign chk_en     = chk_en_i[priv_i];
    assign waiting_q  = (state_q.st == ST_WAIT);
    assign label_q    = state_q.label;
    assign wait_c[0]  = waiting_q;
    assign label_c[0] = label_q;
    assign kill_c[0]  = 1'b0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        lpg_slice u_slice (
            .en_i   (chk_en),
            .valid_i(valid_i[p]),
            .spec_i (spec_i[p]),
            .instr_i(instr_i[p]),
            .ijmp_i (ijmp_i[p]),
            .wen_i  (wen_i[p]),
            .waddr_i(waddr_i[p]),
            .wdata_i(wdata_i[p]),
            .wait_i (wait_c[p]),
            .label_i(label_c[p]),
            .kill_i (kill_c[p]),
            .wait_o (wait_c[p+1]),
            .label_o(label_c[p+1]),
            .kill_o (kill_c[p+1]),
            .allow_o(allow_o[p]),
            .exc_o  (cfi_exc_o[p])
        );
    end

    always_comb begin
        state_d.label = label_c[NUM_PORTS];
        state_d.st    = wait_c[NUM_PORTS] ? ST_WAIT : ST_IDLE;
        if (trap_i || flush_i) begin
            state_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{st: ST_IDLE, label: '0};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
    parameter int NUM_PORTS = 2,
    parameter int NUM_PRIV  = 4,
    parameter int PRIV_W    = 2
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [NUM_PORTS-1:0] valid_i,
    input logic [NUM_PORTS-1:0] spec_i,
    input logic [NUM_PRIV-1:0]  chk_en_i,
    input logic [PRIV_W-1:0]    priv_i,
    input logic                 trap_i,
    input logic                 flush_i,
    input logic [NUM_PORTS-1:0] allow_o,
    input logic [NUM_PORTS-1:0] cfi_exc_o,
    input logic                 waiting_q,
    input logic [31:0]          label_q
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        a_r10_no_allow_and_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(allow_o[p] && cfi_exc_o[p]));
        a_r8_exc_needs_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cfi_exc_o[p] |-> (valid_i[p] && !spec_i[p]));
        a_r8_quiet_when_dead: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!valid_i[p] || spec_i[p]) |-> (!allow_o[p] && !cfi_exc_o[p]));
        if (p > 0) begin : g_up
            a_r10_kill_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
                cfi_exc_o[p-1] |-> (!allow_o[p] && !cfi_exc_o[p]));
        end
    end

    a_r11_disabled_no_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chk_en_i[priv_i] |-> (cfi_exc_o == '0));
    a_r12_trap_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_i || flush_i) |=> !waiting_q);
    a_r3_idle_port0_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !waiting_q |-> !cfi_exc_o[0]);
    a_r8_no_retire_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((valid_i & ~spec_i) == '0 && !trap_i && !flush_i)
        |=> ($stable(waiting_q) && $stable(label_q)));
endmodule

bind lp_retire_guard lpg_checker #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_PRIV (NUM_PRIV),
    .PRIV_W   (PRIV_W)
) u_lpg_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .spec_i   (spec_i),
    .chk_en_i (chk_en_i),
    .priv_i   (priv_i),
    .trap_i   (trap_i),
    .flush_i  (flush_i),
    .allow_o  (allow_o),
    .cfi_exc_o(cfi_exc_o),
    .waiting_q(waiting_q),
    .label_q  (label_q)
);

// File: tb/lp_retire_guard_bench.sv
module lp_retire_guard_bench;
    localparam int NP = 2;
    localparam logic [31:0] NOP = 32'h0000_0013;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        valid, spec, ijmp, wen;
    logic [NP-1:0][31:0]  instr, wdata;
    logic [NP-1:0][4:0]   waddr;
    logic [3:0]           chk_en;
    logic [1:0]           priv;
    logic                 trap, flush;
    logic [NP-1:0]        allow, exc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    lp_retire_guard #(.NUM_PORTS(NP), .NUM_PRIV(4)) u_lp_retire_guard (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .spec_i(spec),
        .instr_i(instr), .ijmp_i(ijmp), .wen_i(wen), .waddr_i(waddr),
        .wdata_i(wdata), .chk_en_i(chk_en), .priv_i(priv), .trap_i(trap),
        .flush_i(flush), .allow_o(allow), .cfi_exc_o(exc)
    );

    function automatic logic [31:0] pad(input logic [19:0] lbl);
        return {lbl, 5'd0, 7'b0010111};
    endfunction

    task automatic clear_all();
        valid = '0; spec = '0; ijmp = '0; wen = '0;
        instr = '{default: NOP}; wdata = '0; waddr = '0;
        trap = 1'b0; flush = 1'b0;
    endtask

    task automatic put(input int p, input logic [31:0] ins, input logic j,
                       input logic w, input logic [31:0] d);
        valid[p] = 1'b1; instr[p] = ins; ijmp[p] = j;
        wen[p] = w; waddr[p] = w ? 5'd7 : 5'd1; wdata[p] = d;
    endtask

    task automatic expect_port(input int p, input logic ea, input logic ee,
                               input string req);
        #2;
        n_tests++;
        if (allow[p] !== ea || exc[p] !== ee) begin
            n_fail++;
            $display("FAIL %s port%0d allow/exc actual %b/%b expected %b/%b",
                     req, p, allow[p], exc[p], ea, ee);
        end
    endtask

    task automatic step();
        @(negedge clk);
        clear_all();
    endtask

    // single retirement on port 0 with expected result, then advance
    task automatic one(input logic [31:0] ins, input logic j, input logic w,
                       input logic [31:0] d, input logic ea, input logic ee,
                       input string req);
        put(0, ins, j, w, d);
        expect_port(0, ea, ee, req);
        step();
    endtask

    task automatic t_reset();
        one(NOP, 0, 0, 0, 1, 0, "R1");
        one(NOP, 1, 0, 0, 1, 0, "R1");
        one(pad(20'h0), 0, 0, 0, 1, 0, "R1");
        one(NOP, 0, 0, 0, 1, 0, "R1");
    endtask

    task automatic t_match();
        one(NOP, 0, 1, 32'h0001_2345, 1, 0, "R7");
        one(NOP, 1, 0, 0, 1, 0, "R3");
        one(pad(20'h12345), 0, 0, 0, 1, 0, "R4");
        one(NOP, 0, 0, 0, 1, 0, "R4");
    endtask

    task automatic t_mismatch();
        one(NOP, 1, 0, 0, 1, 0, "R3");
        one(pad(20'h00001), 0, 0, 0, 0, 1, "R4");
        one(NOP, 0, 0, 0, 0, 1, "R4");
        trap = 1'b1; step();
        one(NOP, 0, 0, 0, 1, 0, "R12");
        one(NOP, 0, 1, 32'h0010_0005, 1, 0, "R7");
        one(NOP, 1, 0, 0, 1, 0, "R3");
        one(pad(20'h00005), 0, 0, 0, 0, 1, "R4");
        flush = 1'b1; step();
        one(NOP, 0, 0, 0, 1, 0, "R12");
    endtask

    task automatic t_idle_pad();
        one(pad(20'hABCDE), 0, 0, 0, 1, 0, "R5");
        one(NOP, 0, 0, 0, 1, 0, "R5");
    endtask

    task automatic t_other();
        one(NOP, 1, 0, 0, 1, 0, "R3");
        one(NOP, 0, 0, 0, 0, 1, "R6");
        trap = 1'b1; step();
        one(NOP, 1, 0, 0, 1, 0, "R3");
        one(NOP, 1, 0, 0, 0, 1, "R6");
        flush = 1'b1; step();
        put(0, NOP, 1, 0, 0); trap = 1'b1;
        expect_port(0, 1, 0, "R12");
        step();
        one(NOP, 0, 0, 0, 1, 0, "R12");
    endtask

    task automatic t_encoding();
        one(NOP, 0, 1, 32'h0000_0ABC, 1, 0, "R2");
        one(NOP, 1, 0, 0, 1, 0, "R2");
        one({20'h00ABC, 5'd5, 7'b0010111}, 0, 0, 0, 0, 1, "R2");
        trap = 1'b1; step();
        one(NOP, 1, 0, 0, 1, 0, "R2");
        one({20'h00ABC, 5'd0, 7'b0110111}, 0, 0, 0, 0, 1, "R2");
        trap = 1'b1; step();
        one(NOP, 1, 0, 0, 1, 0, "R2");
        one(pad(20'h00ABC), 0, 0, 0, 1, 0, "R2");
    endtask

    task automatic t_spec();
        one(NOP, 0, 1, 32'h0000_0042, 1, 0, "R7");
        one(NOP, 1, 0, 0, 1, 0, "R3");
        put(0, NOP, 0, 1, 32'h99); spec[0] = 1'b1;
        expect_port(0, 0, 0, "R8");
        step();
        put(0, NOP, 0, 0, 0); valid[0] = 1'b0;
        expect_port(0, 0, 0, "R8");
        step();
        one(pad(20'h00042), 0, 0, 0, 1, 0, "R8");
        put(0, NOP, 1, 0, 0); spec[0] = 1'b1; step();
        one(NOP, 0, 0, 0, 1, 0, "R8");
    endtask

    task automatic t_chain();
        put(0, NOP, 0, 1, 32'h55); put(1, NOP, 1, 0, 0);
        expect_port(0, 1, 0, "R7"); expect_port(1, 1, 0, "R9");
        step();
        put(0, pad(20'h00055), 0, 0, 0); put(1, NOP, 0, 0, 0);
        expect_port(0, 1, 0, "R7"); expect_port(1, 1, 0, "R9");
        step();
        put(0, NOP, 1, 0, 0); put(1, pad(20'h00055), 0, 0, 0);
        expect_port(0, 1, 0, "R9"); expect_port(1, 1, 0, "R9");
        step();
        one(NOP, 0, 0, 0, 1, 0, "R9");
        put(0, NOP, 1, 0, 0); put(1, NOP, 0, 0, 0);
        expect_port(0, 1, 0, "R9"); expect_port(1, 0, 1, "R9");
        step();
        one(NOP, 0, 0, 0, 0, 1, "R9");
        trap = 1'b1; step();
    endtask

    task automatic t_kill();
        one(NOP, 0, 1, 32'h77, 1, 0, "R10");
        one(NOP, 1, 0, 0, 1, 0, "R10");
        put(0, NOP, 0, 1, 32'h999); put(1, NOP, 1, 0, 0);
        expect_port(0, 0, 1, "R10"); expect_port(1, 0, 0, "R10");
        step();
        one(pad(20'h00077), 0, 0, 0, 1, 0, "R10");
    endtask

    task automatic t_priv();
        chk_en = 4'b1000; priv = 2'd0;
        one(NOP, 1, 0, 0, 1, 0, "R11");
        one(NOP, 0, 0, 0, 1, 0, "R11");
        one(NOP, 0, 1, 32'h321, 1, 0, "R11");
        priv = 2'd3;
        one(NOP, 0, 0, 0, 1, 0, "R11");
        one(NOP, 1, 0, 0, 1, 0, "R11");
        one(pad(20'h00321), 0, 0, 0, 1, 0, "R11");
        one(NOP, 1, 0, 0, 1, 0, "R11");
        priv = 2'd1;
        one(NOP, 0, 0, 0, 1, 0, "R11");
        priv = 2'd3;
        one(NOP, 0, 0, 0, 0, 1, "R11");
        trap = 1'b1; step();
        chk_en = 4'b1111; priv = 2'd0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        clear_all();
        chk_en = 4'b1111; priv = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_match();
        t_mismatch();
        t_idle_pad();
        t_other();
        t_encoding();
        t_spec();
        t_chain();
        t_kill();
        t_priv();
        finish_run();
    end

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog run incomplete actual 0 expected 1");
        finish_run();
    end
endmodule